// File: doc/BRIEF.md
# H-Bridge Nonoverlap Gate Driver

This block turns the 1-bit decision stream of one audio channel's modulator into four gate enables for a full H-bridge: a high-side and a low-side enable on each of two legs. Leg A follows the decision directly and leg B follows its complement. As a result, the high device of one leg always switches together with the low device of the other, and the load sees a differential swing.

On every decision change, each leg releases its conducting device at once. The leg turns the opposite device on only after a dead interval has passed. The interval is chosen by a 3-bit code from eight fixed values between 62 ns and 9 ns. It is stored as a count of cycles of the timing clock, rounded up so the gap is never shorter than asked for. The code is taken once, when reset is released, and is then held. Reset, mute and fault each force all four enables off.

Decisions arrive on a valid/ready stream, typically at half of a 12.288 MHz modulator clock. The block never applies back-pressure once it is running. Ready is low only while the block is held in reset or in the first cycle after release. A producer that sees ready low simply holds its item, and items offered then are not taken.

Top module: `hb_nonoverlap_drv`

## Requirements
- R1: Code `dly_code` selects the dead interval: 0→62 ns, 1→49 ns, 2→37 ns, 3→24 ns, 4→15 ns, 5→13.5 ns, 6→12 ns, 7→9 ns. The interval is held as ceil(ns·1000/TCLK_PS) cycles, with a minimum of 1. For a decision change, the turn-off edge and the following turn-on edge on a leg are exactly that many cycles apart (at 4000 ps: 16, 13, 10, 6, 4, 4, 3, 3).
- R2: The code is captured at the first rising clock edge at which `rst_n` is sampled high. Changes on `dly_code` after that have no effect until the next reset.
- R3: Leg A high is on for decision 1 and leg A low for decision 0. Leg B is the complement of leg A. At all times `gate_hi_a` equals `gate_lo_b` and `gate_lo_a` equals `gate_hi_b`.
- R4: The high and low enables of one leg are never both 1.
- R5: While `rst_n` is low, all four enables are 0 and `dec_ready` is 0 from the next clock edge.
- R6: An edge that samples `mute` or `fault` high drives all four enables to 0. No enable rises while either input stays high.
- R7: After a forced-off period (reset, mute or fault), the first turn-on on a leg comes no sooner than the interval after that leg went off.
- R8: If the decision changes back before a pending turn-on fires, the interval restarts for the new direction. The device that was pending never turns on. For a glitch of g accepted cycles (g below the interval N), the gap becomes N+g.
- R9: `dec_ready` is 1 whenever the block is running. A decision is taken only on an edge with `dec_valid` and `dec_ready` both 1. `dec_bit` presented without `dec_valid` changes no output.
- R10: The conducting devices go off at the second clock edge after the decision is offered, which is one edge after the accepting edge. The new devices turn on at the edge N cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock, period TCLK_PS |
| rst_n | input | 1 | Synchronous active-low reset; its release captures the code |
| mute | input | 1 | High forces all enables off |
| fault | input | 1 | High forces all enables off |
| dly_code | input | 3 | Dead-interval select |
| dec_valid | input | 1 | Decision item valid |
| dec_ready | output | 1 | Decision item accepted when high with valid |
| dec_bit | input | 1 | Modulator decision |
| gate_hi_a | output | 1 | Leg A high-side enable |
| gate_lo_a | output | 1 | Leg A low-side enable |
| gate_hi_b | output | 1 | Leg B high-side enable |
| gate_lo_b | output | 1 | Leg B low-side enable |

## Verification
A decision offered before edge a is accepted at a. The conducting pair drops at a+1, and the new pair rises at a+1+N. A glitch of g cycles moves that rise to a+1+N+g, and a forced-off input acts at the first edge that samples it. The driver samples outputs on the falling clock edge. One edge after it offers a change it confirms the outputs are unchanged, and after the second edge it confirms they are off. For each rise it queues the expected device and gap. The monitor stamps every turn-off and turn-on with the edge count and compares the measured fall-to-rise distance against the queued value: exact after a decision change, at least N after a forced-off period.

// File: rtl/hb_drv_pkg.sv
`timescale 1ns/1ps
package hb_drv_pkg;

  typedef struct packed {
    logic hi;
    logic lo;
  } leg_gate_t;

  // Dead interval in picoseconds for each select value.
  function automatic int unsigned gap_ps(input logic [2:0] sel);
    case (sel)
      3'd0: return 62000;
      3'd1: return 49000;
      3'd2: return 37000;
      3'd3: return 24000;
      3'd4: return 15000;
      3'd5: return 13500;
      3'd6: return 12000;
      default: return 9000;
    endcase
  endfunction

  // Rounded-up cycle count, never below one.
  function automatic int unsigned gap_cycles(input logic [2:0] sel,
                                             input int unsigned tclk_ps);
    int unsigned n;
    n = (gap_ps(sel) + tclk_ps - 1) / tclk_ps;
    if (n < 1) n = 1;
    return n;
  endfunction

endpackage

// File: rtl/hb_code_latch.sv
`timescale 1ns/1ps
module hb_code_latch #(
  parameter int unsigned TCLK_PS = 4000,
  parameter int unsigned CNT_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       code_in,
  output logic             run,
  output logic [CNT_W-1:0] ival
);
  localparam int unsigned NSEL = 8;

  logic [CNT_W-1:0] tbl [NSEL];
  logic             run_q;
  logic [CNT_W-1:0] ival_q;

  for (genvar i = 0; i < NSEL; i++) begin : g_tbl
    assign tbl[i] = CNT_W'(hb_drv_pkg::gap_cycles(3'(i), TCLK_PS));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      ival_q <= tbl[0];
    end else begin
      run_q <= 1'b1;
      if (!run_q) ival_q <= tbl[code_in];
    end
  end

  assign run  = run_q;
  assign ival = ival_q;
endmodule

// File: rtl/hb_dec_in.sv
`timescale 1ns/1ps
module hb_dec_in (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic dec_valid,
  input  logic dec_bit,
  output logic dec_ready,
  output logic dec_q
);
  logic take;

  assign dec_ready = run;
  assign take      = dec_valid && run;

  always_ff @(posedge clk) begin
    if (!rst_n)    dec_q <= 1'b0;
    else if (take) dec_q <= dec_bit;
  end
endmodule

// File: rtl/hb_leg.sv
`timescale 1ns/1ps
module hb_leg #(
  parameter int unsigned CNT_W  = 5,
  parameter bit          INVERT = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  force_off,
  input  logic                  dec,
  input  logic [CNT_W-1:0]      ival,
  output hb_drv_pkg::leg_gate_t gate
);
  logic             want;
  logic             side_q;
  logic [CNT_W-1:0] cnt_q;
  logic             hi_q;
  logic             lo_q;

  assign want = dec ^ INVERT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q   <= 1'b0;
      lo_q   <= 1'b0;
      side_q <= 1'b0;
      cnt_q  <= '0;
    end else if (force_off || (want != side_q)) begin
      // release now, arm the dead interval for the requested side
      hi_q   <= 1'b0;
      lo_q   <= 1'b0;
      side_q <= want;
      cnt_q  <= ival;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) begin
        hi_q <= side_q;
        lo_q <= !side_q;
      end
    end
  end

  assign gate.hi = hi_q;
  assign gate.lo = lo_q;
endmodule

// File: rtl/hb_nonoverlap_drv.sv
`timescale 1ns/1ps
module hb_nonoverlap_drv #(
  parameter int unsigned TCLK_PS = 4000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mute,
  input  logic       fault,
  input  logic [2:0] dly_code,
  input  logic       dec_valid,
  output logic       dec_ready,
  input  logic       dec_bit,
  output logic       gate_hi_a,
  output logic       gate_lo_a,
  output logic       gate_hi_b,
  output logic       gate_lo_b
);
  localparam int unsigned MAX_CYC = hb_drv_pkg::gap_cycles(3'd0, TCLK_PS);
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
  localparam int unsigned NLEG    = 2;

  logic                  run;
  logic [CNT_W-1:0]      ival_w;
  logic                  dec_q;
  logic                  force_off;
  hb_drv_pkg::leg_gate_t legs [NLEG];

  hb_code_latch #(.TCLK_PS(TCLK_PS), .CNT_W(CNT_W)) latch_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .code_in(dly_code),
    .run    (run),
    .ival   (ival_w)
  );

  hb_dec_in dec_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .dec_valid(dec_valid),
    .dec_bit  (dec_bit),
    .dec_ready(dec_ready),
    .dec_q    (dec_q)
  );

  assign force_off = !run || mute || fault;

  for (genvar g = 0; g < NLEG; g++) begin : g_leg
    hb_leg #(.CNT_W(CNT_W), .INVERT(g[0])) leg_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .force_off(force_off),
      .dec      (dec_q),
      .ival     (ival_w),
      .gate     (legs[g])
    );
  end

  assign gate_hi_a = legs[0].hi;
  assign gate_lo_a = legs[0].lo;
  assign gate_hi_b = legs[1].hi;
  assign gate_lo_b = legs[1].lo;
endmodule

// File: rtl/hb_nonoverlap_chk.sv
`timescale 1ns/1ps
module hb_nonoverlap_chk #(
  parameter int unsigned CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mute,
  input logic             fault,
  input logic             dec_ready,
  input logic             gate_hi_a,
  input logic             gate_lo_a,
  input logic             gate_hi_b,
  input logic             gate_lo_b,
  input logic [CNT_W-1:0] ival
);
  logic [CNT_W:0] off_a;
  logic [CNT_W:0] off_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_a <= '0;
      off_b <= '0;
    end else begin
      if (gate_hi_a || gate_lo_a) off_a <= '0;
      else if (off_a != '1)       off_a <= off_a + 1'b1;
      if (gate_hi_b || gate_lo_b) off_b <= '0;
      else if (off_b != '1)       off_b <= off_b + 1'b1;
    end
  end

  // R4
  leg_a_excl_chk: assert property (@(posedge clk) !(gate_hi_a && gate_lo_a));
  // R4
  leg_b_excl_chk: assert property (@(posedge clk) !(gate_hi_b && gate_lo_b));
  // R3
  pair_match_chk: assert property (@(posedge clk)
    (gate_hi_a == gate_lo_b) && (gate_lo_a == gate_hi_b));
  // R5
  reset_off_chk: assert property (@(posedge clk)
    !rst_n |=> !(gate_hi_a || gate_lo_a || gate_hi_b || gate_lo_b || dec_ready));
  // R6
  force_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mute || fault) |=> !(gate_hi_a || gate_lo_a || gate_hi_b || gate_lo_b));
  // R2
  ival_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_ready && $past(dec_ready)) |-> $stable(ival));
  // R1
  gap_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_hi_a) || $rose(gate_lo_a)) |-> (off_a >= {1'b0, ival}));
  // R7
  gap_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_hi_b) || $rose(gate_lo_b)) |-> (off_b >= {1'b0, ival}));
endmodule

bind hb_nonoverlap_drv hb_nonoverlap_chk #(.CNT_W(CNT_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .mute     (mute),
  .fault    (fault),
  .dec_ready(dec_ready),
  .gate_hi_a(gate_hi_a),
  .gate_lo_a(gate_lo_a),
  .gate_hi_b(gate_hi_b),
  .gate_lo_b(gate_lo_b),
  .ival     (ival_w)
);

// File: tb/hb_nonoverlap_drv_tb_top.sv
`timescale 1ns/1ps
module hb_nonoverlap_drv_tb_top;
  localparam int unsigned TCLK_PS = 4000;

  typedef struct {
    logic side;
    int   gap;
    bit   exact;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mute = 1'b0;
  logic       fault = 1'b0;
  logic [2:0] dly_code = 3'd0;
  logic       dec_valid = 1'b0;
  logic       dec_bit = 1'b0;
  logic       dec_ready;
  logic       gate_hi_a, gate_lo_a, gate_hi_b, gate_lo_b;

  int    cyc = 0;
  int    n_chk = 0;
  int    n_err = 0;
  int    excl_bad = 0;
  int    pair_bad = 0;
  bit    done = 1'b0;
  logic  cur = 1'b0;
  int    cur_n = 16;
  item_t exp_q [2][$];
  logic [1:0] prev_hi = 2'b00;
  logic [1:0] prev_lo = 2'b00;
  int    fall_cyc [2] = '{0, 0};

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hb_nonoverlap_drv #(.TCLK_PS(TCLK_PS)) dut_i (
    .clk(clk), .rst_n(rst_n), .mute(mute), .fault(fault),
    .dly_code(dly_code), .dec_valid(dec_valid), .dec_ready(dec_ready),
    .dec_bit(dec_bit), .gate_hi_a(gate_hi_a), .gate_lo_a(gate_lo_a),
    .gate_hi_b(gate_hi_b), .gate_lo_b(gate_lo_b)
  );

  // R1 expected cycle count from the interval table
  function automatic int exp_cycles(input int code);
    int ps;
    int n;
    case (code)
      0: ps = 62000; 1: ps = 49000; 2: ps = 37000; 3: ps = 24000;
      4: ps = 15000; 5: ps = 13500; 6: ps = 12000; default: ps = 9000;
    endcase
    n = (ps + TCLK_PS - 1) / TCLK_PS;
    return (n < 1) ? 1 : n;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic finish_sim();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  // Monitor: stamps edges and compares each turn-on with the scoreboard.
  always @(negedge clk) begin
    logic [1:0] hv;
    logic [1:0] lv;
    hv = {gate_hi_b, gate_hi_a};
    lv = {gate_lo_b, gate_lo_a};
    if (gate_hi_a != gate_lo_b || gate_lo_a != gate_hi_b) pair_bad++;
    for (int l = 0; l < 2; l++) begin
      logic  was_on;
      logic  is_on;
      int    gap;
      item_t it;
      was_on = prev_hi[l] | prev_lo[l];
      is_on  = hv[l] | lv[l];
      if (hv[l] && lv[l]) excl_bad++;
      if ((hv[l] && !prev_hi[l]) || (lv[l] && !prev_lo[l])) begin
        gap = was_on ? 0 : (cyc - fall_cyc[l]);
        if (exp_q[l].size() == 0) begin
          chk(1'b0, "R8", "unexpected turn-on", l, -1);
        end else begin
          it = exp_q[l].pop_front();
          chk(hv[l] == it.side, "R3", "turned-on side (1=high)", int'(hv[l]), int'(it.side));
          if (it.exact) chk(gap == it.gap, "R1", "dead gap cycles", gap, it.gap);
          else          chk(gap >= it.gap, "R7", "gap after forced off (min)", gap, it.gap);
        end
      end
      if (was_on && !is_on) fall_cyc[l] = cyc;
    end
    prev_hi = hv;
    prev_lo = lv;
  end

  task automatic push_both(input logic b, input int gap, input bit exact);
    exp_q[0].push_back('{b, gap, exact});
    exp_q[1].push_back('{!b, gap, exact});
  endtask

  task automatic do_reset(input int code);
    dec_valid = 1'b0;
    rst_n     = 1'b0;
    dly_code  = 3'(code);
    cur_n     = exp_cycles(code);
    repeat (3) @(negedge clk);
    chk(!(gate_hi_a || gate_lo_a || gate_hi_b || gate_lo_b), "R5", "enables in reset",
        int'({gate_hi_a, gate_lo_a, gate_hi_b, gate_lo_b}), 0);
    chk(dec_ready == 1'b0, "R5", "ready in reset", int'(dec_ready), 0);
    rst_n     = 1'b1;
    dec_valid = 1'b1;
    dec_bit   = 1'b1;
    cur       = 1'b1;
    push_both(1'b1, cur_n, 1'b0);
    @(negedge clk);
    chk(dec_ready == 1'b1, "R9", "ready after release", int'(dec_ready), 1);
    dly_code = ~3'(code); // R2: must not alter the captured interval
    repeat (cur_n + 6) @(negedge clk);
  endtask

  task automatic step(input logic b);
    logic old_hi;
    old_hi    = gate_hi_a;
    dec_valid = 1'b1;
    dec_bit   = b;
    if (b == cur) begin
      repeat (cur_n + 4) @(negedge clk);
    end else begin
      push_both(b, cur_n, 1'b1);
      @(negedge clk);
      chk(gate_hi_a == old_hi, "R10", "leg A high at accept edge", int'(gate_hi_a), int'(old_hi));
      @(negedge clk);
      chk(!gate_hi_a && !gate_lo_a, "R10", "leg A off one edge after accept",
          int'({gate_hi_a, gate_lo_a}), 0);
      repeat (cur_n + 2) @(negedge clk);
      cur = b;
    end
  endtask

  // R8: decision flips away for g cycles and comes back (current side is 1)
  task automatic glitch(input int g);
    push_both(1'b1, cur_n + g, 1'b1);
    dec_valid = 1'b1;
    dec_bit   = 1'b0;
    repeat (g) @(negedge clk);
    dec_bit = 1'b1;
    repeat (cur_n + g + 6) @(negedge clk);
  endtask

  // R9: a changed bit without valid must leave the bridge as it is
  task automatic no_valid();
    dec_valid = 1'b0;
    dec_bit   = !cur;
    repeat (cur_n + 4) @(negedge clk);
    chk(gate_hi_a == cur && gate_lo_a == !cur, "R9", "leg A after bit without valid",
        int'({gate_hi_a, gate_lo_a}), int'({cur, !cur}));
    dec_bit   = cur;
    dec_valid = 1'b1;
    @(negedge clk);
  endtask

  // R6 / R7: forced-off via mute (which=0) or fault (which=1)
  task automatic force_test(input bit which);
    if (which) fault = 1'b1; else mute = 1'b1;
    @(negedge clk);
    chk(!(gate_hi_a || gate_lo_a || gate_hi_b || gate_lo_b), "R6", "enables one edge after force",
        int'({gate_hi_a, gate_lo_a, gate_hi_b, gate_lo_b}), 0);
    dec_valid = 1'b1;
    dec_bit   = !cur;
    cur       = !cur;
    repeat (cur_n + 4) @(negedge clk);
    chk(!(gate_hi_a || gate_lo_a || gate_hi_b || gate_lo_b), "R6", "enables while forced",
        int'({gate_hi_a, gate_lo_a, gate_hi_b, gate_lo_b}), 0);
    push_both(cur, cur_n, 1'b0);
    mute  = 1'b0;
    fault = 1'b0;
    repeat (cur_n + 6) @(negedge clk);
    chk(gate_hi_a == cur && gate_lo_a == !cur, "R7", "leg A after force release",
        int'({gate_hi_a, gate_lo_a}), int'({cur, !cur}));
  endtask

  initial begin
    for (int c = 0; c < 8; c++) begin
      do_reset(c);
      step(1'b0);
      step(1'b1);
      step(1'b0);
      step(1'b1);
      glitch(1);
      glitch(cur_n - 1);
      no_valid();
      if (c == 7) force_test(1'b0);
      if (c == 2) force_test(1'b1);
      step(1'b0);
      step(1'b1);
    end
    repeat (4) @(negedge clk);
    chk(exp_q[0].size() == 0 && exp_q[1].size() == 0, "R8", "turn-ons still outstanding",
        exp_q[0].size() + exp_q[1].size(), 0);
    chk(excl_bad == 0, "R4", "cycles with both devices of a leg on", excl_bad, 0);
    chk(pair_bad == 0, "R3", "cycles with legs not complementary", pair_bad, 0);
    finish_sim();
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "R1", "watchdog expired", cyc, 0);
    finish_sim();
  end
endmodule